// File: doc/BRIEF.md
# Processor reset conditioning and vector-fetch sequencer

This block conditions the reset of a 16-bit processor core in the 8-bit microprocessor lineage and runs the bus cycles that follow the reset. An active-low reset request counts only after it has been sampled low on at least a set number of consecutive clock edges (two by default). While the request is active, the block holds the architectural registers at defined values and drives quiet, read-only bus qualifiers. After release it runs a fixed interrupt-style sequence:

- two internal cycles;
- three stack-address cycles that only read;
- two vector reads from bank 0.

It then loads the program counter from the fetched vector and presents an opcode fetch at that address.

The core around it sees a 24-bit address, a read/write strobe and a two-bit cycle qualifier pair. It also sees an active-low vector-pull strobe and the emulation and register-width status. A small register load port, which works only in the running state, lets the core change the conditioned registers. The same port lets a bench set known values before a reset.

Top module: `cpu_reset_seq`

## Requirements
- R1: A reset request takes effect only after `res_ni` has been low at HOLD_CYC (default 2) consecutive rising edges. In the running state, a single low sample changes no output and no register. After power-on (`rst_ni`), the block waits in reset conditioning until a full-length request has been released.
- R2: `rdy_i` has no effect in reset conditioning. Release starts the sequence even with `rdy_i` low. During the sequence, `rdy_i` low stalls the current cycle, and `rdy_i` high advances one cycle per clock.
- R3: On every clock edge in reset conditioning, the following registers are loaded:
  - direct register 0x0000;
  - data bank and program bank 0x00;
  - stack high byte 0x01;
  - index X and Y high bytes 0x00.

  The stack low byte and the index low bytes keep their values.
- R4: Reset conditioning also does the following:
  - sets status bits M (bit 5), X (bit 4) and I (bit 2);
  - clears D (bit 3);
  - keeps N (7), V (6), Z (1) and C (0);
  - sets emulation;
  - clears the stopped and waiting states.
- R5: In reset conditioning the outputs are `rw_o`=1, `vda_o`=0, `vpa_o`=0, `vp_no`=1, `mx_o`=1 and `emu_o`=1.
- R6: After release, the sequence runs in this order:
  - two internal cycles;
  - three stack cycles at addresses 0x0001ss, where ss starts at the stack low byte and falls by one per cycle.

  The stack low byte ends three lower. `rw_o` stays 1 throughout.
- R7: The two cycles after the stack cycles read address 0x00FFFC and then 0x00FFFD, with `vp_no`=0. `vp_no` is 1 in every other cycle.
- R8: After the high vector byte is read, the program counter becomes {high, low} and the program bank stays 0x00. The next cycle is an opcode fetch at 0x00{high, low}.
- R9: If `res_ni` is low on any edge while the sequence is running, the block returns at once to reset conditioning and the hold count starts again. The sequence restarts only after a release that follows a full-length hold.
- R10: The qualifier pair {`vda_o`, `vpa_o`} is 00 for an internal cycle, 01 for a program address, 10 for a data address (stack and vector cycles) and 11 for an opcode fetch. In the running state, a stopped or waiting core shows 00.
- R11: In the running state only, `wr_en_i` loads `wr_data_i` into the register chosen by `wr_sel_i`:
  - 0 direct;
  - 1 X;
  - 2 Y;
  - 3 stack;
  - 4 data bank (low byte);
  - 5 program bank (low byte);
  - 6 status (low byte);
  - 7 emulation (bit 0).

  `mx_o` in the running state is status M AND X. `stp_i` and `wai_i` set the stopped and waiting states.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous power-on reset, active low |
| res_ni | input | 1 | Processor reset request, active low, synchronous |
| rdy_i | input | 1 | Ready; low stalls the sequence |
| rdata_i | input | 8 | Read data bus |
| stp_i | input | 1 | Enter stopped state (running state only) |
| wai_i | input | 1 | Enter waiting state (running state only) |
| wr_en_i | input | 1 | Register load enable |
| wr_sel_i | input | 3 | Register load select |
| wr_data_i | input | 16 | Register load data |
| addr_o | output | 24 | Bus address |
| rw_o | output | 1 | Read (1) / write (0) |
| vda_o | output | 1 | Valid data address qualifier |
| vpa_o | output | 1 | Valid program address qualifier |
| vp_no | output | 1 | Vector pull, active low |
| mx_o | output | 1 | Width status, 1 when both M and X are 8-bit |
| emu_o | output | 1 | Emulation status |
| stopped_o | output | 1 | Stopped state |
| waiting_o | output | 1 | Waiting state |
| dir_o | output | 16 | Direct register |
| x_o | output | 16 | Index X |
| y_o | output | 16 | Index Y |
| sp_o | output | 16 | Stack pointer |
| dbr_o | output | 8 | Data bank |
| pbr_o | output | 8 | Program bank |
| p_o | output | 8 | Status register |

## Verification
Three situations are hard to reach from the ports:
- A reset request that lands in the middle of the stack cycles. This case rests on a single-cycle request between two longer ones.
- A release under `rdy_i` low. The bench keeps `rdy_i` low across both the hold and the release, then raises it. It checks that the first stack cycle appears exactly two cycles later.
- Proof that reset conditioning preserves N, V, Z, C and the stack and index low bytes. The bench first loads distinctive values through the load port and stops the core, so that both the preserved bits and the cleared stop state are visible.

For the mid-sequence case, the bench counts the cycles into a sequence and pulls `res_ni` low on the first stack cycle for one clock only. It then watches the block stay idle for eight cycles before it sends a full request.

// File: rtl/cpu_rs_pkg.sv
package cpu_rs_pkg;
  localparam int BW = 8;
  localparam int WW = 2 * BW;
  localparam int AW = 3 * BW;

  localparam int P_N = 7;
  localparam int P_V = 6;
  localparam int P_M = 5;
  localparam int P_X = 4;
  localparam int P_D = 3;
  localparam int P_I = 2;

  localparam logic [BW-1:0] P_SET_MASK = BW'((1 << P_M) | (1 << P_X) | (1 << P_I));
  localparam logic [BW-1:0] P_CLR_MASK = BW'(1 << P_D);

  typedef enum logic [3:0] {
    S_RES, S_INT0, S_INT1, S_STK0, S_STK1, S_STK2, S_VLO, S_VHI, S_RUN
  } seq_st_e;

  typedef enum logic [2:0] {
    SEL_D, SEL_X, SEL_Y, SEL_SP, SEL_DBR, SEL_PBR, SEL_P, SEL_E
  } reg_sel_e;
endpackage

// File: rtl/cpu_rs_filter.sv
module cpu_rs_filter #(
  parameter int HOLD_CYC = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic res_ni,
  output logic hit_o,
  output logic armed_o
);
  localparam int CW = $clog2(HOLD_CYC + 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                      cnt_q <= '0;
    else if (res_ni)                  cnt_q <= '0;
    else if (cnt_q != CW'(HOLD_CYC))  cnt_q <= cnt_q + CW'(1);
  end

  // this low sample completes the hold
  assign hit_o   = !res_ni && (cnt_q >= CW'(HOLD_CYC - 1));
  assign armed_o = (cnt_q == CW'(HOLD_CYC));

  // R1: one isolated low sample never qualifies
  a_r1_single_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!res_ni && $past(res_ni)) |-> !hit_o);
endmodule

// File: rtl/cpu_rs_fsm.sv
module cpu_rs_fsm import cpu_rs_pkg::*; #(
  parameter logic [WW-1:0] VEC_ADDR = 16'hFFFC
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          res_ni,
  input  logic          rdy_i,
  input  logic          hit_i,
  input  logic          armed_i,
  input  logic          stp_i,
  input  logic          wai_i,
  input  logic [WW-1:0] sp_i,
  input  logic [BW-1:0] pbr_i,
  input  logic [WW-1:0] pc_i,
  output logic [AW-1:0] addr_o,
  output logic          rw_o,
  output logic          vda_o,
  output logic          vpa_o,
  output logic          vp_no,
  output logic          stopped_o,
  output logic          waiting_o,
  output logic          force_o,
  output logic          run_o,
  output logic          sp_dec_o,
  output logic          lo_we_o,
  output logic          pc_we_o
);
  seq_st_e st_q, st_d;
  logic    adv;

  always_comb begin
    st_d = st_q;
    if (!res_ni) begin
      if (st_q != S_RUN || hit_i) st_d = S_RES;
    end else begin
      case (st_q)
        S_RES:   st_d = armed_i ? S_INT0 : S_RES;
        S_RUN:   st_d = S_RUN;
        default: if (rdy_i) begin
          case (st_q)
            S_INT0:  st_d = S_INT1;
            S_INT1:  st_d = S_STK0;
            S_STK0:  st_d = S_STK1;
            S_STK1:  st_d = S_STK2;
            S_STK2:  st_d = S_VLO;
            S_VLO:   st_d = S_VHI;
            default: st_d = S_RUN;
          endcase
        end
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) st_q <= S_RES;
    else         st_q <= st_d;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stopped_o <= 1'b0;
      waiting_o <= 1'b0;
    end else if (st_q == S_RES) begin
      stopped_o <= 1'b0;
      waiting_o <= 1'b0;
    end else if (st_q == S_RUN) begin
      if (stp_i) stopped_o <= 1'b1;
      if (wai_i) waiting_o <= 1'b1;
    end
  end

  assign adv      = res_ni && rdy_i && st_q != S_RES && st_q != S_RUN;
  assign force_o  = (st_q == S_RES);
  assign run_o    = (st_q == S_RUN);
  assign sp_dec_o = adv && (st_q == S_STK0 || st_q == S_STK1 || st_q == S_STK2);
  assign lo_we_o  = adv && (st_q == S_VLO);
  assign pc_we_o  = adv && (st_q == S_VHI);

  always_comb begin
    addr_o = {pbr_i, pc_i};
    rw_o   = 1'b1;
    vda_o  = 1'b0;
    vpa_o  = 1'b0;
    vp_no  = 1'b1;
    case (st_q)
      S_STK0, S_STK1, S_STK2: begin
        vda_o  = 1'b1;
        addr_o = {{BW{1'b0}}, sp_i};
      end
      S_VLO: begin
        vda_o  = 1'b1;
        vp_no  = 1'b0;
        addr_o = {{BW{1'b0}}, VEC_ADDR};
      end
      S_VHI: begin
        vda_o  = 1'b1;
        vp_no  = 1'b0;
        addr_o = {{BW{1'b0}}, VEC_ADDR | WW'(1)};
      end
      S_RUN: if (!stopped_o && !waiting_o) begin
        vda_o = 1'b1;
        vpa_o = 1'b1;
      end
      default: ;
    endcase
  end

  a_r2_release_ignores_rdy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == S_RES && res_ni && armed_i && !rdy_i) |=> (st_q == S_INT0));
  a_r7_vector_pair: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!vp_no && addr_o[WW-1:0] == VEC_ADDR && res_ni && rdy_i) |=>
      (!vp_no && addr_o == {{BW{1'b0}}, VEC_ADDR | WW'(1)}));
  a_r9_abort_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q != S_RUN && !res_ni) |=> (!vda_o && !vpa_o && vp_no && rw_o));
  a_r10_pull_is_data: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !vp_no |-> (vda_o && !vpa_o));
endmodule

// File: rtl/cpu_rs_regs.sv
module cpu_rs_regs import cpu_rs_pkg::*; #(
  parameter logic [BW-1:0] STK_PAGE = 8'h01
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          force_i,
  input  logic          run_i,
  input  logic          sp_dec_i,
  input  logic          lo_we_i,
  input  logic          pc_we_i,
  input  logic [BW-1:0] rdata_i,
  input  logic          wr_en_i,
  input  logic [2:0]    wr_sel_i,
  input  logic [WW-1:0] wr_data_i,
  output logic [WW-1:0] dir_o,
  output logic [WW-1:0] x_o,
  output logic [WW-1:0] y_o,
  output logic [WW-1:0] sp_o,
  output logic [BW-1:0] dbr_o,
  output logic [BW-1:0] pbr_o,
  output logic [BW-1:0] p_o,
  output logic          e_o,
  output logic [WW-1:0] pc_o
);
  logic [BW-1:0] vlo_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dir_o <= '0;
      x_o   <= '0;
      y_o   <= '0;
      sp_o  <= {STK_PAGE, {BW{1'b1}}};
      dbr_o <= '0;
      pbr_o <= '0;
      p_o   <= P_SET_MASK;
      e_o   <= 1'b1;
      pc_o  <= '0;
      vlo_q <= '0;
    end else if (force_i) begin
      dir_o           <= '0;
      x_o[WW-1:BW]    <= '0;
      y_o[WW-1:BW]    <= '0;
      sp_o[WW-1:BW]   <= STK_PAGE;
      dbr_o           <= '0;
      pbr_o           <= '0;
      p_o             <= (p_o | P_SET_MASK) & ~P_CLR_MASK;
      e_o             <= 1'b1;
    end else begin
      if (sp_dec_i) sp_o[BW-1:0] <= sp_o[BW-1:0] - BW'(1);
      if (lo_we_i)  vlo_q <= rdata_i;
      if (pc_we_i)  pc_o  <= {rdata_i, vlo_q};
      if (wr_en_i && run_i) begin
        case (reg_sel_e'(wr_sel_i))
          SEL_D:   dir_o <= wr_data_i;
          SEL_X:   x_o   <= wr_data_i;
          SEL_Y:   y_o   <= wr_data_i;
          SEL_SP:  sp_o  <= wr_data_i;
          SEL_DBR: dbr_o <= wr_data_i[BW-1:0];
          SEL_PBR: pbr_o <= wr_data_i[BW-1:0];
          SEL_P:   p_o   <= wr_data_i[BW-1:0];
          default: e_o   <= wr_data_i[0];
        endcase
      end
    end
  end

  a_r3_forced_regs: assert property (@(posedge clk_i) disable iff (!rst_ni)
    force_i |=> (dir_o == '0 && dbr_o == '0 && pbr_o == '0 && sp_o[WW-1:BW] == STK_PAGE
                 && x_o[WW-1:BW] == '0 && y_o[WW-1:BW] == '0
                 && sp_o[BW-1:0] == $past(sp_o[BW-1:0])));
  a_r4_forced_flags: assert property (@(posedge clk_i) disable iff (!rst_ni)
    force_i |=> (p_o[P_M] && p_o[P_X] && p_o[P_I] && !p_o[P_D] && e_o
                 && p_o[P_N:P_V] == $past(p_o[P_N:P_V]) && p_o[1:0] == $past(p_o[1:0])));
  a_r6_stack_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sp_dec_i |=> (sp_o[BW-1:0] == $past(sp_o[BW-1:0]) - BW'(1)
                  && sp_o[WW-1:BW] == $past(sp_o[WW-1:BW])));
  a_r8_pc_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pc_we_i |=> (pc_o[WW-1:BW] == $past(rdata_i) && pbr_o == '0));
endmodule

// File: rtl/cpu_reset_seq.sv
module cpu_reset_seq import cpu_rs_pkg::*; #(
  parameter int            HOLD_CYC = 2,
  parameter logic [WW-1:0] VEC_ADDR = 16'hFFFC,
  parameter logic [BW-1:0] STK_PAGE = 8'h01
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          res_ni,
  input  logic          rdy_i,
  input  logic [BW-1:0] rdata_i,
  input  logic          stp_i,
  input  logic          wai_i,
  input  logic          wr_en_i,
  input  logic [2:0]    wr_sel_i,
  input  logic [WW-1:0] wr_data_i,
  output logic [AW-1:0] addr_o,
  output logic          rw_o,
  output logic          vda_o,
  output logic          vpa_o,
  output logic          vp_no,
  output logic          mx_o,
  output logic          emu_o,
  output logic          stopped_o,
  output logic          waiting_o,
  output logic [WW-1:0] dir_o,
  output logic [WW-1:0] x_o,
  output logic [WW-1:0] y_o,
  output logic [WW-1:0] sp_o,
  output logic [BW-1:0] dbr_o,
  output logic [BW-1:0] pbr_o,
  output logic [BW-1:0] p_o
);
  logic          hit, armed, force_c, run_c, sp_dec, lo_we, pc_we, e_q;
  logic [WW-1:0] pc;

  cpu_rs_filter #(.HOLD_CYC(HOLD_CYC)) i_filter (
    .clk_i, .rst_ni, .res_ni, .hit_o(hit), .armed_o(armed)
  );

  cpu_rs_fsm #(.VEC_ADDR(VEC_ADDR)) i_fsm (
    .clk_i, .rst_ni, .res_ni, .rdy_i, .hit_i(hit), .armed_i(armed),
    .stp_i, .wai_i, .sp_i(sp_o), .pbr_i(pbr_o), .pc_i(pc),
    .addr_o, .rw_o, .vda_o, .vpa_o, .vp_no, .stopped_o, .waiting_o,
    .force_o(force_c), .run_o(run_c), .sp_dec_o(sp_dec), .lo_we_o(lo_we), .pc_we_o(pc_we)
  );

  cpu_rs_regs #(.STK_PAGE(STK_PAGE)) i_regs (
    .clk_i, .rst_ni, .force_i(force_c), .run_i(run_c), .sp_dec_i(sp_dec),
    .lo_we_i(lo_we), .pc_we_i(pc_we), .rdata_i, .wr_en_i, .wr_sel_i, .wr_data_i,
    .dir_o, .x_o, .y_o, .sp_o, .dbr_o, .pbr_o, .p_o, .e_o(e_q), .pc_o(pc)
  );

  assign mx_o  = force_c | (p_o[P_M] & p_o[P_X]);
  assign emu_o = force_c | e_q;

  // R5: outputs in reset conditioning
  a_r5_reset_outputs: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!res_ni && $past(!res_ni) && $past(hit)) |-> (rw_o && !vda_o && !vpa_o && vp_no && mx_o && emu_o));
endmodule

// File: tb/test_cpu_reset_seq.sv
`timescale 1ns/1ps
module test_cpu_reset_seq;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        res_n = 1'b1;
  logic        rdy = 1'b1;
  logic [7:0]  rdata;
  logic        stp = 1'b0, wai = 1'b0, wr_en = 1'b0;
  logic [2:0]  wr_sel = '0;
  logic [15:0] wr_data = '0;
  logic [23:0] addr;
  logic        rw, vda, vpa, vp_n, mx, emu, stopped, waiting;
  logic [15:0] dir, xr, yr, sp;
  logic [7:0]  dbr, pbr, p;
  logic [15:0] mem_vec = 16'h8000;
  int          n_chk = 0, n_err = 0;
  bit          done = 1'b0;

  always #4 clk = ~clk;

  always_comb begin
    if (addr == 24'h00FFFC)      rdata = mem_vec[7:0];
    else if (addr == 24'h00FFFD) rdata = mem_vec[15:8];
    else                         rdata = 8'hEA;
  end

  cpu_reset_seq i_cpu_reset_seq (
    .clk_i(clk), .rst_ni(rst_n), .res_ni(res_n), .rdy_i(rdy), .rdata_i(rdata),
    .stp_i(stp), .wai_i(wai), .wr_en_i(wr_en), .wr_sel_i(wr_sel), .wr_data_i(wr_data),
    .addr_o(addr), .rw_o(rw), .vda_o(vda), .vpa_o(vpa), .vp_no(vp_n), .mx_o(mx), .emu_o(emu),
    .stopped_o(stopped), .waiting_o(waiting), .dir_o(dir), .x_o(xr), .y_o(yr), .sp_o(sp),
    .dbr_o(dbr), .pbr_o(pbr), .p_o(p)
  );

  // row: {vda, vpa, vp_n, kind}; kind 0 no addr, 1..3 stack k-1, 4 vec lo, 5 vec hi, 6 fetch
  localparam logic [5:0] SEQ [8] = '{
    {3'b001, 3'd0}, {3'b001, 3'd0}, {3'b101, 3'd1}, {3'b101, 3'd2},
    {3'b101, 3'd3}, {3'b100, 3'd4}, {3'b100, 3'd5}, {3'b111, 3'd6}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic chk_reset_out(input string tag);
    chk(tag, {26'd0, vda, vpa, vp_n, rw, mx, emu}, 32'b001111);
  endtask

  // assumes the caller aligned to a negedge right after release
  task automatic walk(input int first, input logic [7:0] sp0, input logic [15:0] vec);
    for (int k = first; k < 8; k++) begin
      logic [23:0] ea;
      @(negedge clk);
      chk($sformatf("R6/R7/R10 row%0d qual", k), {29'd0, vda, vpa, vp_n}, {29'd0, SEQ[k][5:3]});
      chk($sformatf("R6 row%0d rw", k), {31'd0, rw}, 32'd1);
      case (SEQ[k][2:0])
        3'd1, 3'd2, 3'd3: ea = {8'h00, 8'h01, sp0 - 8'(SEQ[k][2:0] - 3'd1)};
        3'd4: ea = 24'h00FFFC;
        3'd5: ea = 24'h00FFFD;
        3'd6: ea = {8'h00, vec};
        default: ea = addr;
      endcase
      chk($sformatf("R6/R7/R8 row%0d addr", k), {8'd0, addr}, {8'd0, ea});
    end
    chk("R6 sp after", {16'd0, sp}, {16'd0, 8'h01, sp0 - 8'd3});
    chk("R8 bank", {24'd0, pbr}, 32'd0);
  endtask

  task automatic do_reset(input int n);
    @(negedge clk) res_n = 1'b0;
    repeat (n) @(negedge clk);
    res_n = 1'b1;
  endtask

  task automatic wr(input logic [2:0] sel, input logic [15:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = sel; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk_reset_out("R5 power-on");
    repeat (3) @(negedge clk);
    chk_reset_out("R1 waits for request");

    do_reset(3);
    walk(0, 8'hFF, 16'h8000);

    wr(3'd0, 16'hBEEF); wr(3'd1, 16'hA5C3); wr(3'd2, 16'h5AFF); wr(3'd3, 16'h0342);
    wr(3'd4, 16'h007E); wr(3'd5, 16'h0012); wr(3'd6, 16'h00CB); wr(3'd7, 16'h0000);
    @(negedge clk);
    chk("R11 dir", {16'd0, dir}, 32'hBEEF);
    chk("R11 x", {16'd0, xr}, 32'hA5C3);
    chk("R11 sp", {16'd0, sp}, 32'h0342);
    chk("R11 p", {24'd0, p}, 32'hCB);
    chk("R11 mx/emu", {30'd0, mx, emu}, 32'd0);
    chk("R10 fetch at bank", {8'd0, addr}, 32'h00128000);
    chk("R10 fetch qual", {30'd0, vda, vpa}, 32'b11);

    // single low sample in running state
    @(negedge clk) res_n = 1'b0;
    @(negedge clk) res_n = 1'b1;
    @(negedge clk);
    chk("R1 glitch qual", {30'd0, vda, vpa}, 32'b11);
    chk("R1 glitch regs", {dir, 8'd0, dbr}, {16'hBEEF, 8'd0, 8'h7E});

    @(negedge clk) begin stp = 1'b1; wai = 1'b1; end
    @(negedge clk) begin stp = 1'b0; wai = 1'b0; end
    chk("R11 stop/wait", {30'd0, stopped, waiting}, 32'b11);
    chk("R10 stopped qual", {30'd0, vda, vpa}, 32'b00);

    // reset with rdy low throughout
    mem_vec = 16'h1234;
    @(negedge clk) begin rdy = 1'b0; res_n = 1'b0; end
    @(negedge clk);
    @(negedge clk);
    chk_reset_out("R5 with rdy low");
    @(negedge clk);
    chk("R3 dir", {16'd0, dir}, 32'd0);
    chk("R3 x/y", {xr, yr}, {16'h00C3, 16'h00FF});
    chk("R3 sp", {16'd0, sp}, 32'h0142);
    chk("R3 banks", {16'd0, dbr, pbr}, 32'd0);
    chk("R4 p", {24'd0, p}, 32'hF7);
    chk("R4 emu/stop/wait", {29'd0, emu, stopped, waiting}, 32'b100);
    res_n = 1'b1;
    repeat (3) @(negedge clk);
    chk("R2 stalled", {31'd0, vda}, 32'd0);
    rdy = 1'b1;
    walk(1, 8'h42, 16'h1234);

    // abort in first stack cycle
    mem_vec = 16'hC0DE;
    do_reset(3);
    @(negedge clk);
    @(negedge clk);
    @(negedge clk);
    chk("R9 in stack", {8'd0, addr}, 32'h0000013F);
    res_n = 1'b0;
    @(negedge clk);
    chk_reset_out("R9 abort");
    res_n = 1'b1;
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      chk("R9 parked", {30'd0, vda, vp_n}, 32'b01);
    end
    do_reset(2);
    walk(0, 8'h3F, 16'hC0DE);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog act=running exp=done");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end
endmodule